// File: doc/BRIEF.md
# ADC Lane Word Aligner

This block brings the deserialized data lanes of a serial-output ADC into alignment before live capture starts. While the ADC sends a fixed 12-bit training word on every lane, a host command starts a fixed sequence. First the block resets the input clock buffer and the delay elements. Next it resets the deserializers. It then sweeps the input delay of every lane to find the widest window of stable data. Finally it issues bitslip pulses until each lane's parallel word equals the training word.

All lanes are trained together on one shared schedule. Each lane ends either locked or failed. When every lane has reached one of those two states, the block raises a done flag, and an error flag if any lane failed. After that it holds its tap and slip settings untouched while the host switches the ADC back to live samples.

Top module: `adc_lane_aligner`

## Requirements
- R1: After reset the block is idle, with busy, done, lock and fail flags low. It drives no delay, bitslip or reset pulse until `start` is sampled high.
- R2: An accepted start drives `dly_rst` high for RST_CYC cycles. On the very next cycle `serdes_rst` goes high for RST_CYC cycles. The two are never high together.
- R3: The sweep visits taps 0 to TAPS-1 in order. At each tap it waits SETTLE cycles and then takes STABLE consecutive words. A tap is stable when all of those words are equal.
- R4: Each lane picks the longest run of consecutive stable taps, taking the earliest run on a tie, and chooses tap start + (length-1)/2, rounded down. The block applies it with a one-cycle `dly_rst` followed by that many `dly_inc` pulses.
- R5: A lane with no stable tap is marked failed and gets no increments and no bitslips.
- R6: The lane word is compared with the training word 12'b000111000111, with the word's bit 11 being the first serial bit. A lane that does not match gets a bitslip pulse. A lane that matches is locked and receives no further pulses.
- R7: Consecutive bitslip pulses are exactly SETTLE+1 cycles apart, so that SETTLE cycles separate each pulse from the next comparison.
- R8: A lane that still does not match after 12 bitslips is marked failed.
- R9: `done` rises only when every lane is locked or failed. `error` equals done ANDed with any fail. `busy` is high from the accepted start until done.
- R10: A start that arrives while busy is ignored, and the run takes the same number of cycles as an undisturbed run.
- R11: While done and without a new start, the block drives no delay, bitslip or reset pulse, and its lock, fail and done outputs stay constant, whatever the lane data.
- R12: A start after done clears done, lock and fail and repeats the whole sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Host training command |
| lane_word | input | LANES*WORD_W | Parallel words, lane l in bits [l*WORD_W +: WORD_W] |
| dly_rst | output | 1 | Reset of clock buffer and delay taps (taps to 0) |
| serdes_rst | output | 1 | Deserializer reset |
| dly_inc | output | LANES | One-tap delay increment per lane |
| bitslip | output | LANES | Bitslip strobe per lane |
| lane_lock | output | LANES | Lane aligned to training word |
| lane_fail | output | LANES | Lane could not be aligned |
| busy | output | 1 | Training sequence running |
| done | output | 1 | Training finished |
| error | output | 1 | Finished with at least one failed lane |

## Verification
Each result has a fixed distance from its cause. `dly_rst` appears on the edge that samples start, and `serdes_rst` follows RST_CYC cycles later. Each tap costs SETTLE+STABLE cycles, the tap load takes TAPS+SETTLE+1 cycles, and each bitslip round takes SETTLE+1 cycles. The bench therefore samples only on falling edges. It checks the reset order by counting consecutive high samples, and it checks the slip spacing by timing successive pulses in the delay and deserializer stub. Final taps, slip counts and flags are read only once done has been seen, and hold behaviour is judged over a fixed 200-cycle window of live data.

// File: rtl/adc_lane_aligner.sv
module adc_lane_aligner #(
  parameter int LANES   = 2,
  parameter int WORD_W  = 12,
  parameter logic [WORD_W-1:0] PATTERN = 12'b000111000111,
  parameter int TAPS    = 32,
  parameter int STABLE  = 64,
  parameter int SETTLE  = 4,
  parameter int RST_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LANES*WORD_W-1:0] lane_word,
  output logic                    dly_rst,
  output logic                    serdes_rst,
  output logic [LANES-1:0]        dly_inc,
  output logic [LANES-1:0]        bitslip,
  output logic [LANES-1:0]        lane_lock,
  output logic [LANES-1:0]        lane_fail,
  output logic                    busy,
  output logic                    done,
  output logic                    error
);
  localparam int TW = $clog2(TAPS + 1);
  localparam int CW = $clog2(TAPS + SETTLE + STABLE + RST_CYC + 2);
  localparam int SW = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {IDLE, BRST, SRST, SCAN, LOAD, SLIP, FIN} st_t;
  st_t state;

  logic [CW-1:0]     cnt;
  logic [TW-1:0]     tap;
  logic [SW-1:0]     slips;
  logic [LANES-1:0]  ok, stab, better;
  logic [WORD_W-1:0] wd [LANES];
  logic [WORD_W-1:0] refw [LANES];
  logic [TW-1:0]     cur_len [LANES];
  logic [TW-1:0]     best_len [LANES];
  logic [TW-1:0]     best_st [LANES];
  logic [TW-1:0]     run_n [LANES];
  logic [TW-1:0]     blen_n [LANES];
  logic [TW-1:0]     bst_n [LANES];
  logic [TW-1:0]     centre [LANES];

  assign busy  = (state != IDLE) && (state != FIN);
  assign error = done && (|lane_fail);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      wd[l]     = lane_word[l*WORD_W +: WORD_W];
      stab[l]   = ok[l] && (wd[l] == refw[l]);
      run_n[l]  = stab[l] ? cur_len[l] + TW'(1) : '0;
      better[l] = run_n[l] > best_len[l];
      blen_n[l] = better[l] ? run_n[l] : best_len[l];
      bst_n[l]  = better[l] ? tap + TW'(1) - run_n[l] : best_st[l];
      centre[l] = best_st[l] + ((best_len[l] - TW'(1)) >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; cnt <= '0; tap <= '0; slips <= '0; ok <= '0;
      dly_rst <= 1'b0; serdes_rst <= 1'b0; dly_inc <= '0; bitslip <= '0;
      lane_lock <= '0; lane_fail <= '0; done <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        refw[l] <= '0; cur_len[l] <= '0; best_len[l] <= '0; best_st[l] <= '0;
      end
    end else begin
      dly_rst <= 1'b0; serdes_rst <= 1'b0; dly_inc <= '0; bitslip <= '0;
      case (state)
        IDLE, FIN: if (start) begin
          state <= BRST; cnt <= '0; dly_rst <= 1'b1;
          done <= 1'b0; lane_lock <= '0; lane_fail <= '0;
        end
        BRST: if (cnt == CW'(RST_CYC - 1)) begin
          serdes_rst <= 1'b1; cnt <= '0; state <= SRST;
        end else begin
          dly_rst <= 1'b1; cnt <= cnt + CW'(1);
        end
        SRST: if (cnt == CW'(RST_CYC - 1)) begin
          cnt <= '0; tap <= '0; ok <= '0; state <= SCAN;
          for (int l = 0; l < LANES; l++) begin
            cur_len[l] <= '0; best_len[l] <= '0; best_st[l] <= '0;
          end
        end else begin
          serdes_rst <= 1'b1; cnt <= cnt + CW'(1);
        end
        SCAN: begin
          cnt <= cnt + CW'(1);
          for (int l = 0; l < LANES; l++) begin
            if (cnt == CW'(SETTLE)) begin
              refw[l] <= wd[l]; ok[l] <= 1'b1;
            end else if (cnt > CW'(SETTLE)) ok[l] <= stab[l];
          end
          if (cnt == CW'(SETTLE + STABLE - 1)) begin
            cnt <= '0;
            for (int l = 0; l < LANES; l++) begin
              cur_len[l] <= run_n[l]; best_len[l] <= blen_n[l]; best_st[l] <= bst_n[l];
            end
            if (tap == TW'(TAPS - 1)) begin
              state <= LOAD; dly_rst <= 1'b1;
              for (int l = 0; l < LANES; l++) lane_fail[l] <= (blen_n[l] == '0);
            end else begin
              tap <= tap + TW'(1); dly_inc <= '1;
            end
          end
        end
        LOAD: begin
          cnt <= cnt + CW'(1);
          for (int l = 0; l < LANES; l++)
            dly_inc[l] <= (cnt < CW'(centre[l])) && !lane_fail[l];
          if (cnt == CW'(TAPS + SETTLE)) begin
            cnt <= '0; slips <= '0; state <= SLIP;
          end
        end
        SLIP: if (&(lane_lock | lane_fail)) begin
          state <= FIN; done <= 1'b1;
        end else if (cnt == CW'(SETTLE)) begin
          cnt <= '0; slips <= slips + SW'(1);
          for (int l = 0; l < LANES; l++) begin
            if (!lane_lock[l] && !lane_fail[l]) begin
              if (wd[l] == PATTERN)          lane_lock[l] <= 1'b1;
              else if (slips == SW'(WORD_W)) lane_fail[l] <= 1'b1;
              else                           bitslip[l]   <= 1'b1;
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_lane_aligner_chk.sv
module adc_lane_aligner_chk #(
  parameter int LANES  = 2,
  parameter int SETTLE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             dly_rst,
  input logic             serdes_rst,
  input logic [LANES-1:0] dly_inc,
  input logic [LANES-1:0] bitslip,
  input logic [LANES-1:0] lane_lock,
  input logic [LANES-1:0] lane_fail,
  input logic             busy,
  input logic             done,
  input logic             error
);
  localparam int GW = $clog2(SETTLE + 2) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)                gap <= '1;
    else if (|bitslip)         gap <= '0;
    else if (gap != '1)        gap <= gap + GW'(1);
  end

  assert_rst_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    serdes_rst |-> !dly_rst);

  assert_slip_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|bitslip) |-> (gap >= GW'(SETTLE)));

  assert_done_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&(lane_lock | lane_fail)));

  assert_busy_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_error_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && dly_inc == '0 && bitslip == '0 && !dly_rst
                          && !serdes_rst && $stable(lane_lock) && $stable(lane_fail)));
endmodule

bind adc_lane_aligner adc_lane_aligner_chk #(.LANES(LANES), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dly_rst(dly_rst), .serdes_rst(serdes_rst),
  .dly_inc(dly_inc), .bitslip(bitslip), .lane_lock(lane_lock), .lane_fail(lane_fail),
  .busy(busy), .done(done), .error(error));

// File: tb/adc_lane_aligner_test.sv
module adc_lane_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam int LN = 2, WW = 12, NT = 32, NS = 64, ST = 4, RC = 4;
  localparam logic [WW-1:0] PAT = 12'b000111000111;

  logic clk = 0, rst_n = 0, start = 0;
  logic [LN*WW-1:0] lane_word;
  logic dly_rst, serdes_rst, busy, done, error;
  logic [LN-1:0] dly_inc, bitslip, lane_lock, lane_fail;

  int nchk = 0, nerr = 0;
  int tapv [LN], slipv [LN], lastslip [LN];
  int cyc = 0, act = 0, gap_err = 0, gap_seen = 0;
  logic [NT-1:0] mask [LN];
  int off [LN];
  bit good [LN];
  bit live = 0;

  adc_lane_aligner #(.LANES(LN), .WORD_W(WW), .PATTERN(PAT), .TAPS(NT), .STABLE(NS),
    .SETTLE(ST), .RST_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_word(lane_word), .dly_rst(dly_rst),
    .serdes_rst(serdes_rst), .dly_inc(dly_inc), .bitslip(bitslip), .lane_lock(lane_lock),
    .lane_fail(lane_fail), .busy(busy), .done(done), .error(error));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WW-1:0] rotl(logic [WW-1:0] w, int r);
    int s = r % WW;
    if (s == 0) return w;
    return (w << s) | (w >> (WW - s));
  endfunction

  always_comb begin
    for (int l = 0; l < LN; l++) begin
      if (live) lane_word[l*WW +: WW] = WW'(cyc * 37 + l * 5);
      else if (mask[l][tapv[l]])
        lane_word[l*WW +: WW] = rotl(good[l] ? PAT : 12'h801, off[l] + slipv[l]);
      else lane_word[l*WW +: WW] = WW'(cyc) ^ WW'(l);
    end
  end

  // delay-element and deserializer stub
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dly_rst || serdes_rst || (|dly_inc) || (|bitslip)) act <= act + 1;
    for (int l = 0; l < LN; l++) begin
      if (!rst_n) begin
        tapv[l] <= 0; slipv[l] <= 0; lastslip[l] <= -1;
      end else begin
        if (dly_rst) tapv[l] <= 0;
        else if (dly_inc[l] && tapv[l] < NT - 1) tapv[l] <= tapv[l] + 1;
        if (serdes_rst) begin
          slipv[l] <= 0; lastslip[l] <= -1;
        end else if (bitslip[l]) begin
          slipv[l] <= slipv[l] + 1; lastslip[l] <= cyc;
          if (lastslip[l] >= 0) begin
            gap_seen <= gap_seen + 1;
            if (cyc - lastslip[l] != ST + 1) gap_err <= gap_err + 1;
          end
        end
      end
    end
  end

  task automatic check(bit ok, string req, int actv, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  function automatic int exp_centre(logic [NT-1:0] m);
    int cur = 0, bl = 0, bs = 0;
    for (int t = 0; t < NT; t++) begin
      cur = m[t] ? cur + 1 : 0;
      if (cur > bl) begin bl = cur; bs = t + 1 - cur; end
    end
    return (bl == 0) ? -1 : bs + (bl - 1) / 2;
  endfunction

  function automatic int exp_slips(int o);
    for (int k = 0; k <= WW; k++) if (rotl(PAT, o + k) == PAT) return k;
    return WW;
  endfunction

  task automatic train(input int inject, output int n);
    int dr = 0, sr = 0, dr_at = -1;
    bit seen_sr = 0, both = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(!done && lane_lock == 0 && lane_fail == 0 && busy, "R12 status cleared on start",
          {done, lane_lock, lane_fail}, 0);
    n = 1;
    while (1) begin
      if (serdes_rst) begin
        if (!seen_sr) dr_at = dr;
        seen_sr = 1; sr++;
        if (dly_rst) both = 1;
      end
      if (dly_rst && !seen_sr) dr++;
      if (done || n >= 30000) break;
      start = (n == inject);
      @(negedge clk);
      n++;
    end
    start = 0;
    check(done, "R9 done reached", done, 1);
    check(dr_at == RC, "R2 dly_rst length before serdes_rst", dr_at, RC);
    check(sr == RC && !both, "R2 serdes_rst length", sr, RC);
  endtask

  task automatic verify(string tag);
    bit anyfail = 0;
    for (int l = 0; l < LN; l++) begin
      int c = exp_centre(mask[l]);
      if (c < 0) begin
        anyfail = 1;
        check(lane_fail[l] && !lane_lock[l], "R5 no eye fails lane", lane_fail[l], 1);
        check(tapv[l] == 0, "R5 no increments", tapv[l], 0);
        check(slipv[l] == 0, "R5 no bitslips", slipv[l], 0);
      end else begin
        check(tapv[l] == c, "R3 R4 centre tap", tapv[l], c);
        if (good[l]) begin
          check(lane_lock[l] && !lane_fail[l], "R6 lane locks", lane_lock[l], 1);
          check(slipv[l] == exp_slips(off[l]), "R6 bitslip count", slipv[l], exp_slips(off[l]));
        end else begin
          anyfail = 1;
          check(lane_fail[l] && !lane_lock[l], "R8 lane fails", lane_fail[l], 1);
          check(slipv[l] == WW, "R8 twelve bitslips", slipv[l], WW);
        end
      end
    end
    check(error == anyfail && !busy, {"R9 error flag ", tag}, error, anyfail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int n1, n4, a0, t0, s0;
    for (int l = 0; l < LN; l++) begin mask[l] = '0; off[l] = 0; good[l] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !error && lane_lock == 0 && lane_fail == 0, "R1 reset state", busy, 0);
    a0 = act;
    repeat (100) @(negedge clk);
    check(act == a0 && !busy && !done, "R1 idle without start", act - a0, 0);

    // S1: single run and split runs, offsets 2 and 0
    mask[0] = 32'h0000_07F8; off[0] = 2;
    mask[1] = 32'h7FF0_0007; off[1] = 0;
    train(-1, n1);
    verify("S1");

    // hold through live data
    live = 1; a0 = act; t0 = tapv[0]; s0 = slipv[0];
    repeat (200) @(negedge clk);
    check(act == a0, "R11 no pulses after done", act - a0, 0);
    check(done && lane_lock == 2'b11 && tapv[0] == t0 && slipv[0] == s0,
          "R11 settings held", {done, lane_lock}, 7);
    live = 0;

    // S2: tie between equal runs, lane without eye
    mask[0] = 32'h0000_3C3C; off[0] = 5;
    mask[1] = 32'h0;         off[1] = 0;
    train(-1, n4);
    verify("S2");

    // S3: eye at last tap only, full eye with wrong word
    mask[0] = 32'h8000_0000; off[0] = 11;
    mask[1] = 32'hFFFF_FFFF; good[1] = 0;
    train(-1, n4);
    verify("S3");

    // S4: repeat S1 with a start while busy
    mask[0] = 32'h0000_07F8; off[0] = 2;
    mask[1] = 32'h7FF0_0007; off[1] = 0; good[1] = 1;
    train(500, n4);
    verify("S4");
    check(n4 == n1, "R10 busy start ignored, duration", n4, n1);

    check(gap_seen > 0 && gap_err == 0, "R7 bitslip spacing", gap_err, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule